// File: doc/BRIEF.md
# In-Order Micro-Op Dispatch Limiter

This block sits between instruction decode and the issue queues of an in-order dispatch stage. Decode hands it one instruction per clock, each carrying a micro-op count and a queue tag for every micro-op. The block holds a few accepted instructions in a small window. Every clock it sends out as many micro-ops as the rules allow, strictly in program order, on three output lanes.

Two kinds of limit apply in every clock. The first is a global width of three micro-ops. The second is a set of caps, one per dispatch queue, plus an aggregate cap shared by the floating-point queues. The first micro-op that breaks any limit stops dispatch for that clock, and every younger micro-op waits for the next one. A run-time mode input adds the no-cross rule: an instruction that cannot place all of its remaining micro-ops into the lanes still free is moved whole to the next clock.

Top module: `uop_dispatch_limiter`

## Requirements
- R1: After reset no lane is valid, `bubble` is low and `inReady` is high.
- R2: At most three micro-ops leave in one clock. Valid lanes are packed from lane 0, and a lower lane always carries an older micro-op.
- R3: Tag codes are 0 branch, 1 integer, 2 multi-cycle integer, 3 FP pipe 0, 4 FP pipe 1, 5 load, 6 store, 7 FP any pipe. The per-clock caps are: branch 1, integer 2, multi-cycle integer 2, FP pipe 0 1, FP pipe 1 1, and loads plus stores together 2.
- R4: Micro-ops tagged 3, 4 or 7 together take at most two lanes per clock.
- R5: Dispatch stops at the first micro-op that would break the width or any cap. No younger micro-op leaves in that clock, even one that would fit.
- R6: With `noCross` low, an instruction may be split across clocks. Its remaining micro-ops resume from lane 0 in a later clock, in order.
- R7: With `noCross` high, an instruction that is not first in the clock is held to the next clock when its remaining micro-ops outnumber the free lanes. The fit test counts lanes only. An instruction with four micro-ops still spills across clocks.
- R8: A count of 0 is dispatched as one micro-op using tag field 0. A count above 4 is dispatched as four micro-ops.
- R9: Micro-op j of an instruction takes its tag from `inTags[3j+2:3j]`. An accepted instruction can dispatch no earlier than the clock after the one in which it is accepted.
- R10: `bubble` is high in exactly those clocks where an instruction is held and fewer than three lanes are valid.
- R11: An instruction is accepted at a clock edge where `inValid` and `inReady` are both high. `inReady` is high exactly when fewer than DEPTH instructions are held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| noCross | input | 1 | Selects the no-cross placement rule |
| inValid | input | 1 | Instruction offered |
| inReady | output | 1 | Room in the window for an instruction |
| inCount | input | 3 | Micro-op count of the offered instruction |
| inTags | input | 12 | Four 3-bit queue tags, micro-op 0 in the low bits |
| slotValid | output | 3 | Lane carries a micro-op this clock |
| slotTag | output | 9 | Queue tag for each lane, lane 0 in the low bits |
| bubble | output | 1 | An instruction is held and a lane went unused |

## Verification
The hardest state to reach from the ports is a window holding several instructions at once. Input arrives at one instruction per clock, so without help the window drains as fast as it fills, and the caps only ever meet micro-ops of a single instruction. The stimulus therefore leads each directed case with a four-micro-op branch instruction. It drains at one micro-op per clock under the branch cap, and while it does, the instructions behind it pile up. When it clears, a full window meets the width, queue, aggregate and no-cross rules together. A long randomized stream, with mode changes and idle gaps mixed in, then runs against the bench's own model of the rules.

// File: rtl/udl_pkg.sv
`timescale 1ns/1ps
package udl_pkg;
  localparam int SLOTS    = 3;
  localparam int MAX_UOPS = 4;
  localparam int TAG_W    = 3;
  localparam int TAGS_W   = MAX_UOPS * TAG_W;
  localparam int CNT_W    = $clog2(MAX_UOPS + 1);
  localparam int IDX_W    = $clog2(MAX_UOPS);
  localparam int POP_W    = $clog2(SLOTS + 1);
  localparam int LANE_W   = $clog2(SLOTS);

  // queue tag codes
  localparam logic [TAG_W-1:0] Q_BR  = 3'd0;
  localparam logic [TAG_W-1:0] Q_INT = 3'd1;
  localparam logic [TAG_W-1:0] Q_MUL = 3'd2;
  localparam logic [TAG_W-1:0] Q_FP0 = 3'd3;
  localparam logic [TAG_W-1:0] Q_FP1 = 3'd4;
  localparam logic [TAG_W-1:0] Q_LD  = 3'd5;
  localparam logic [TAG_W-1:0] Q_ST  = 3'd6;
  localparam logic [TAG_W-1:0] Q_FPX = 3'd7;

  // per-clock caps
  localparam int CAP_BR  = 1;
  localparam int CAP_INT = 2;
  localparam int CAP_MUL = 2;
  localparam int CAP_FP0 = 1;
  localparam int CAP_FP1 = 1;
  localparam int CAP_LS  = 2;
  localparam int CAP_FPA = 2;

  typedef struct packed {
    logic [CNT_W-1:0]  cnt;
    logic [TAGS_W-1:0] tags;
  } instr_t;

  // control -> datapath strobes
  typedef struct packed {
    logic [POP_W-1:0] pop;
    logic [IDX_W-1:0] headIdx;
  } strobe_t;

  function automatic logic [CNT_W-1:0] normCount(input logic [CNT_W-1:0] raw);
    if (raw == '0) return CNT_W'(1);
    if (raw > CNT_W'(MAX_UOPS)) return CNT_W'(MAX_UOPS);
    return raw;
  endfunction
endpackage

// File: rtl/udl_window.sv
`timescale 1ns/1ps
module udl_window
  import udl_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [CNT_W-1:0]  inCount,
  input  logic [TAGS_W-1:0] inTags,
  input  strobe_t           strobe,
  output instr_t            win [SLOTS],
  output logic [SLOTS-1:0]  winValid,
  output logic [IDX_W-1:0]  headIdx
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int OCC_W = $clog2(DEPTH + 1);

  instr_t           store [DEPTH];
  logic [PTR_W-1:0] rdPtr;
  logic [PTR_W-1:0] wrPtr;
  logic [OCC_W-1:0] occ;
  logic             push;

  assign inReady = occ < OCC_W'(DEPTH);
  assign push    = inValid && inReady;

  // oldest SLOTS entries are visible to the control
  generate
    for (genvar k = 0; k < SLOTS; k++) begin : g_win
      assign win[k]      = store[PTR_W'((int'(rdPtr) + k) % DEPTH)];
      assign winValid[k] = int'(occ) > k;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr   <= '0;
      wrPtr   <= '0;
      occ     <= '0;
      headIdx <= '0;
    end else begin
      if (push) wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      rdPtr   <= PTR_W'((int'(rdPtr) + int'(strobe.pop)) % DEPTH);
      occ     <= OCC_W'(int'(occ) + int'(push) - int'(strobe.pop));
      headIdx <= strobe.headIdx;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      store[wrPtr].cnt  <= normCount(inCount);
      store[wrPtr].tags <= inTags;
    end
  end
endmodule

// File: rtl/udl_control.sv
`timescale 1ns/1ps
module udl_control
  import udl_pkg::*;
(
  input  logic             noCross,
  input  instr_t           win [SLOTS],
  input  logic [SLOTS-1:0] winValid,
  input  logic [IDX_W-1:0] headIdx,
  output logic [SLOTS-1:0] slotValid,
  output logic [TAG_W-1:0] slotTag [SLOTS],
  output logic             bubble,
  output strobe_t          strobe
);
  int               used, start, n, pops;
  int               nBr, nInt, nMul, nFp0, nFp1, nLs, nFpa;
  logic             halt, ok;
  logic [IDX_W-1:0] idxNext;
  logic [TAG_W-1:0] tg;

  always_comb begin
    slotValid = '0;
    for (int s = 0; s < SLOTS; s++) slotTag[s] = '0;
    used = 0; pops = 0; start = 0; n = 0;
    nBr = 0; nInt = 0; nMul = 0; nFp0 = 0; nFp1 = 0; nLs = 0; nFpa = 0;
    halt = 1'b0; ok = 1'b0; tg = '0;
    idxNext = headIdx;

    for (int k = 0; k < SLOTS; k++) begin
      if (!halt && winValid[k]) begin
        start = (k == 0) ? int'(headIdx) : 0;
        n     = int'(win[k].cnt);
        // whole-instruction placement when the mode asks for it
        if (noCross && used > 0 && (n - start) > (SLOTS - used)) halt = 1'b1;
        for (int j = 0; j < MAX_UOPS; j++) begin
          if (!halt && j >= start && j < n) begin
            tg = win[k].tags[j*TAG_W +: TAG_W];
            case (tg)
              Q_BR:       ok = nBr  < CAP_BR;
              Q_INT:      ok = nInt < CAP_INT;
              Q_MUL:      ok = nMul < CAP_MUL;
              Q_FP0:      ok = (nFp0 < CAP_FP0) && (nFpa < CAP_FPA);
              Q_FP1:      ok = (nFp1 < CAP_FP1) && (nFpa < CAP_FPA);
              Q_LD, Q_ST: ok = nLs  < CAP_LS;
              default:    ok = nFpa < CAP_FPA;
            endcase
            if (ok && used < SLOTS) begin
              slotValid[LANE_W'(used)] = 1'b1;
              slotTag[LANE_W'(used)]   = tg;
              used = used + 1;
              case (tg)
                Q_BR:       nBr  = nBr + 1;
                Q_INT:      nInt = nInt + 1;
                Q_MUL:      nMul = nMul + 1;
                Q_FP0:      begin nFp0 = nFp0 + 1; nFpa = nFpa + 1; end
                Q_FP1:      begin nFp1 = nFp1 + 1; nFpa = nFpa + 1; end
                Q_LD, Q_ST: nLs  = nLs + 1;
                default:    nFpa = nFpa + 1;
              endcase
            end else begin
              halt    = 1'b1;
              idxNext = IDX_W'(j);
            end
          end
        end
        if (!halt) begin
          pops    = pops + 1;
          idxNext = '0;
        end
      end
    end

    bubble         = winValid[0] && (used < SLOTS);
    strobe.pop     = POP_W'(pops);
    strobe.headIdx = idxNext;
  end
endmodule

// File: rtl/uop_dispatch_limiter.sv
`timescale 1ns/1ps
module uop_dispatch_limiter
  import udl_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   noCross,
  input  logic                   inValid,
  output logic                   inReady,
  input  logic [CNT_W-1:0]       inCount,
  input  logic [TAGS_W-1:0]      inTags,
  output logic [SLOTS-1:0]       slotValid,
  output logic [SLOTS*TAG_W-1:0] slotTag,
  output logic                   bubble
);
  instr_t           win [SLOTS];
  logic [SLOTS-1:0] winValid;
  logic [IDX_W-1:0] headIdx;
  logic [TAG_W-1:0] laneTag [SLOTS];
  strobe_t          strobe;

  udl_window #(.DEPTH(DEPTH)) u_window (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inCount(inCount), .inTags(inTags), .strobe(strobe),
    .win(win), .winValid(winValid), .headIdx(headIdx)
  );

  udl_control u_control (
    .noCross(noCross), .win(win), .winValid(winValid), .headIdx(headIdx),
    .slotValid(slotValid), .slotTag(laneTag), .bubble(bubble), .strobe(strobe)
  );

  generate
    for (genvar s = 0; s < SLOTS; s++) begin : g_lane
      assign slotTag[s*TAG_W +: TAG_W] = laneTag[s];
    end
  endgenerate
endmodule

// File: rtl/udl_checker.sv
`timescale 1ns/1ps
module udl_checker
  import udl_pkg::*;
(
  input logic                   clk,
  input logic                   rstN,
  input logic                   inValid,
  input logic                   inReady,
  input logic [SLOTS-1:0]       slotValid,
  input logic [SLOTS*TAG_W-1:0] slotTag,
  input logic                   bubble
);
  int   cBr, cInt, cMul, cFp0, cFp1, cLs, cFpa;
  logic packedOk;

  always_comb begin
    cBr = 0; cInt = 0; cMul = 0; cFp0 = 0; cFp1 = 0; cLs = 0; cFpa = 0;
    for (int s = 0; s < SLOTS; s++) begin
      if (slotValid[s]) begin
        case (slotTag[s*TAG_W +: TAG_W])
          Q_BR:       cBr  = cBr + 1;
          Q_INT:      cInt = cInt + 1;
          Q_MUL:      cMul = cMul + 1;
          Q_FP0:      begin cFp0 = cFp0 + 1; cFpa = cFpa + 1; end
          Q_FP1:      begin cFp1 = cFp1 + 1; cFpa = cFpa + 1; end
          Q_LD, Q_ST: cLs  = cLs + 1;
          default:    cFpa = cFpa + 1;
        endcase
      end
    end
    packedOk = (int'(slotValid) == ((1 << $countones(slotValid)) - 1));
  end

  // R2
  lanes_packed_chk: assert property (@(posedge clk) disable iff (!rstN) packedOk);

  // R3
  queue_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cBr <= CAP_BR) && (cInt <= CAP_INT) && (cMul <= CAP_MUL) &&
    (cFp0 <= CAP_FP0) && (cFp1 <= CAP_FP1) && (cLs <= CAP_LS));

  // R4
  fp_pair_cap_chk: assert property (@(posedge clk) disable iff (!rstN) cFpa <= CAP_FPA);

  // R10
  bubble_partial_chk: assert property (@(posedge clk) disable iff (!rstN)
    bubble |-> (slotValid[0] && !(&slotValid)));

  // R11
  accept_issue_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> slotValid[0]);
endmodule

bind uop_dispatch_limiter udl_checker u_chk (.*);

// File: tb/tb_uop_dispatch_limiter.sv
`timescale 1ns/1ps
module tb_uop_dispatch_limiter;
  localparam int DEPTH = 4;
  localparam int BR = 0, INT = 1, MUL = 2, F0 = 3, F1 = 4, LD = 5, ST = 6, FX = 7;

  logic        clk = 1'b0, rstN = 1'b0, noCross = 1'b0, inValid = 1'b0;
  logic        inReady, bubble;
  logic [2:0]  inCount = '0;
  logic [11:0] inTags = '0;
  logic [2:0]  slotValid;
  logic [8:0]  slotTag;

  always #2.5 clk = ~clk;

  uop_dispatch_limiter #(.DEPTH(DEPTH)) dut (.*);

  int    compared = 0, mismatched = 0;
  string curReq = "R1";

  // reference model state
  int mCnt[$];
  int mTags[$];
  int mHead = 0;
  int eValid, ePop, eIdx;
  int eTag[3];
  bit eBub, eReady;

  function automatic bit room(int t, int c[8]);
    int fp;
    fp = c[3] + c[4] + c[7];
    case (t)
      0: return c[0] < 1;
      1: return c[1] < 2;
      2: return c[2] < 2;
      3: return c[3] < 1 && fp < 2;
      4: return c[4] < 1 && fp < 2;
      5, 6: return c[5] + c[6] < 2;
      default: return fp < 2;
    endcase
  endfunction

  function void evalModel();
    int used, st, n, t;
    int c[8];
    bit halt;
    used = 0; halt = 0; ePop = 0; eIdx = mHead; eValid = 0;
    for (int i = 0; i < 3; i++) eTag[i] = 0;
    for (int i = 0; i < 8; i++) c[i] = 0;
    for (int k = 0; k < mCnt.size() && k < 3 && !halt; k++) begin
      st = (k == 0) ? mHead : 0;
      n  = mCnt[k];
      if (noCross && used > 0 && n - st > 3 - used) halt = 1;
      for (int j = st; j < n && !halt; j++) begin
        t = (mTags[k] >> (3 * j)) & 7;
        if (used < 3 && room(t, c)) begin
          eValid |= (1 << used); eTag[used] = t; used++; c[t]++;
        end else begin
          halt = 1; eIdx = j;
        end
      end
      if (!halt) begin ePop++; eIdx = 0; end
    end
    eBub = (mCnt.size() > 0) && (used < 3);
  endfunction

  // compare on every clock, then step the model past the coming edge
  always @(negedge clk) begin
    bit bad;
    int c;
    #1;
    if (!rstN) begin
      mCnt.delete(); mTags.delete(); mHead = 0;
    end else begin
      evalModel();
      eReady = mCnt.size() < DEPTH;
      bad = (inReady !== eReady) || (slotValid !== 3'(eValid)) || (bubble !== eBub);
      for (int s = 0; s < 3; s++)
        if (eValid[s] && slotTag[3*s +: 3] !== 3'(eTag[s])) bad = 1;
      compared++;
      if (bad) begin
        mismatched++;
        $display("FAIL %s t=%0t: ready=%b valid=%b tags=%o bubble=%b expected ready=%b valid=%b tags=%o%o%o bubble=%b",
                 curReq, $time, inReady, slotValid, slotTag, bubble,
                 eReady, 3'(eValid), eTag[2], eTag[1], eTag[0], eBub);
      end
      for (int p = 0; p < ePop; p++) begin
        void'(mCnt.pop_front()); void'(mTags.pop_front());
      end
      mHead = eIdx;
      if (inValid && eReady) begin
        c = int'(inCount);
        if (c == 0) c = 1;
        if (c > 4) c = 4;
        mCnt.push_back(c);
        mTags.push_back(int'(inTags));
      end
    end
  end

  function automatic logic [11:0] pk(int a, int b = 0, int c = 0, int d = 0);
    return 12'(a | (b << 3) | (c << 6) | (d << 9));
  endfunction

  task automatic send(int cnt, logic [11:0] tags);
    bit got;
    inValid = 1'b1; inCount = 3'(cnt); inTags = tags;
    got = 0;
    while (!got) begin
      got = inReady;
      @(negedge clk);
    end
  endtask

  task automatic idle(int n);
    inValid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // four branch micro-ops drain one per clock and let the window fill
  task automatic blocker();
    send(4, pk(BR, BR, BR, BR));
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    compared++;
    if (slotValid !== 3'b000 || inReady !== 1'b1 || bubble !== 1'b0) begin
      mismatched++;
      $display("FAIL R1: valid=%b ready=%b bubble=%b expected valid=000 ready=1 bubble=0",
               slotValid, inReady, bubble);
    end
    @(negedge clk);

    curReq = "R9";  // tag field order and one-clock latency
    send(1, pk(INT)); send(1, pk(LD)); send(2, pk(F0, INT)); send(1, pk(BR));
    send(3, pk(MUL, ST, F1)); idle(4);

    curReq = "R2";  // width three across several queued instructions
    blocker(); send(1, pk(INT)); send(1, pk(LD)); send(1, pk(MUL)); send(1, pk(FX)); idle(6);

    curReq = "R3";  // per-queue caps
    blocker(); send(2, pk(INT, INT)); send(1, pk(INT)); send(2, pk(LD, ST)); idle(6);
    blocker(); send(1, pk(BR)); send(1, pk(BR)); send(2, pk(ST, LD)); idle(6);
    blocker(); send(1, pk(F0)); send(1, pk(F0)); send(2, pk(MUL, MUL)); idle(6);

    curReq = "R4";  // shared FP cap
    blocker(); send(1, pk(F0)); send(1, pk(FX)); send(1, pk(F1)); idle(6);
    blocker(); send(2, pk(FX, FX)); send(1, pk(F1)); send(1, pk(INT)); idle(6);

    curReq = "R5";  // stop at first blocked micro-op
    blocker(); send(1, pk(BR)); send(1, pk(INT)); send(1, pk(LD)); idle(6);
    blocker(); send(3, pk(INT, INT, INT)); send(1, pk(LD)); idle(6);

    curReq = "R6";  // split across clocks with mode low
    noCross = 1'b0;
    blocker(); send(1, pk(INT)); send(3, pk(LD, MUL, FX)); send(1, pk(ST)); idle(6);
    send(4, pk(LD, ST, INT, MUL)); send(4, pk(F0, F0, F1, F1)); idle(8);

    curReq = "R7";  // no-cross placement
    noCross = 1'b1;
    blocker(); send(1, pk(INT)); send(3, pk(LD, MUL, FX)); send(2, pk(INT, MUL)); idle(6);
    blocker(); send(2, pk(INT, MUL)); send(4, pk(LD, INT, MUL, BR)); idle(8);
    blocker(); send(1, pk(INT)); send(2, pk(INT, INT)); idle(6);
    noCross = 1'b0;

    curReq = "R8";  // count normalisation
    blocker(); send(0, pk(MUL, BR, BR, BR)); send(7, pk(INT, LD, MUL, ST)); send(0, pk(FX)); idle(8);

    curReq = "R11"; // window fills and ready drops
    blocker(); send(1, pk(BR)); send(1, pk(BR)); send(1, pk(BR)); send(1, pk(BR)); send(1, pk(BR));
    idle(10);

    curReq = "R10"; // randomized stream, both modes
    for (int i = 0; i < 400; i++) begin
      if (($urandom % 16) == 0) noCross = ~noCross;
      send(int'($urandom % 8), 12'($urandom));
      if (($urandom % 8) == 0) idle(int'($urandom % 3));
    end
    idle(12);

    summary();
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: run did not end, expected completion");
    summary();
    $finish;
  end
endmodule